// File: doc/BRIEF.md
# Back-EMF Locked Sine Sample Sequencer

This block keeps a sine-drive profile in step with a spinning motor using nothing but counters. A comparator watching the undriven winding gives a zero-crossing signal. Only its rising edge counts. The block times each electrical period with a slow timer that advances once every 48 system clocks. It keeps the last measured count, Tc, and uses it to split the next period into 48 equal sample intervals.

A down counter runs at the full clock rate. It is reloaded with Tc and fires a one-cycle sample strobe each time it runs out. A profile address counter steps once per strobe. It tells the downstream duty-cycle logic which of the 48 profile entries applies in the current sample interval.

When the motor slows or stops, the address holds at the last entry and the timer holds at full scale. A stall flag reports that no zero crossing came before the timer filled up. While the enable is low, the block is quiet and forgets its lock.

Top module: `bemf_sample_seq`

## Requirements
- R1: After reset, `tc` is all ones, `stall` is 0, `sample_stb` is 0 and `prof_addr` is 0.
- R2: A zero-crossing event is a cycle in which `zc_in` is 1, was 0 in the cycle before, and `en` is 1. Take D as the number of clocks from the previous event to this one. The previous event may instead be the last cycle with `en` low. In the cycle after the event, `tc` equals floor(D/48), and `stall` is 0.
- R3: When floor(D/48) is 0, `tc` becomes 1 instead.
- R4: After an event in cycle c that captured a value T, `sample_stb` is high for one cycle at each cycle c + k*T + 1 (k = 1, 2, ...). This continues for every such cycle up to and including the cycle of the next event, or the cycle in which `en` falls. No other strobes occur.
- R5: `prof_addr` is 0 in the cycle after an event. It then rises by one in the cycle after each strobe, so during the k-th strobe it reads k-1.
- R6: `prof_addr` saturates at 47 and never wraps before the next event.
- R7: Only the rising edge of `zc_in` matters. Holding it high or letting it fall creates no event and does not disturb the strobe schedule.
- R8: The period timer saturates at its all-ones value. `stall` goes to 1 once more than all-ones × 48 clocks have passed without an event, and stays 1 until the next event. The value captured at that event is all ones.
- R9: While `en` is 0, `sample_stb` is 0, `prof_addr` is 0 and `stall` is 0, rising edges on `zc_in` are ignored, and `tc` keeps its value.
- R10: After reset, and after `en` rises, no strobe occurs until the first zero-crossing event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Block enable |
| zc_in | input | 1 | Synchronous zero-crossing comparator output; rising edge used |
| tc | output | TC_W (16) | Last measured period in units of 48 clocks |
| stall | output | 1 | Period timer saturated with no zero crossing |
| sample_stb | output | 1 | One-cycle sample strobe |
| prof_addr | output | 6 | Profile entry for the current sample interval |

## Verification
The hardest state to reach is timer saturation with the stall flag set. With the default width it needs millions of clocks. The bench therefore builds the block with an 8-bit period width, so a gap of about 12,300 clocks fills the timer.

Just before that long gap, the bench leaves a captured period of 2 in force. As a result, thousands of strobes pile up against the saturated address during the stall. A gap shorter than 48 clocks forces the zero-to-one substitution. Disable windows with an edge inside them cover the ignore and re-arm paths.

// File: rtl/bemf_seq_pkg.sv
package bemf_seq_pkg;
  // samples per electrical period
  localparam int DEF_SAMPLES = 48;
  // width of the period measurement
  localparam int DEF_TC_W    = 16;
endpackage

// File: rtl/bemf_period_timer.sv
module bemf_period_timer #(
  parameter int N_SAMP = 48,
  parameter int TC_W   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            zc_in,
  output logic            zc_evt,
  output logic [TC_W-1:0] tc_meas,
  output logic [TC_W-1:0] tc_q,
  output logic            stall_q
);
  localparam int PRE_W = (N_SAMP > 1) ? $clog2(N_SAMP) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST  = PRE_W'(N_SAMP - 1);
  localparam logic [PRE_W-1:0] PRE_START = PRE_W'(1);
  localparam logic [TC_W-1:0]  CNT_MAX   = {TC_W{1'b1}};

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [TC_W-1:0]  cnt_q, cnt_d, tc_d;
  logic             stall_d, zc_q, tick;

  assign zc_evt  = en & zc_in & ~zc_q;
  assign tick    = (pre_q == PRE_LAST);
  assign tc_meas = (cnt_q == '0) ? TC_W'(1) : cnt_q;

  always_comb begin
    pre_d   = pre_q;
    cnt_d   = cnt_q;
    tc_d    = tc_q;
    stall_d = stall_q;
    if (!en) begin
      pre_d   = PRE_START;
      cnt_d   = '0;
      stall_d = 1'b0;
    end else if (zc_evt) begin
      pre_d   = PRE_START;
      cnt_d   = '0;
      stall_d = 1'b0;
      tc_d    = tc_meas;
    end else begin
      pre_d = tick ? '0 : pre_q + PRE_W'(1);
      if (tick) begin
        if (cnt_q == CNT_MAX) stall_d = 1'b1;
        else                  cnt_d   = cnt_q + TC_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= PRE_START;
      cnt_q   <= '0;
      tc_q    <= CNT_MAX;
      stall_q <= 1'b0;
      zc_q    <= 1'b0;
    end else begin
      pre_q   <= pre_d;
      cnt_q   <= cnt_d;
      tc_q    <= tc_d;
      stall_q <= stall_d;
      zc_q    <= zc_in;
    end
  end

  p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    zc_evt |=> (cnt_q == '0) && !stall_q);
  p_tc_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    zc_evt |=> (tc_q != '0));
  p_stall_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall_q |-> (cnt_q == CNT_MAX));
  p_stall_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_q && en && !zc_evt) |=> stall_q);
endmodule

// File: rtl/bemf_sample_divider.sv
module bemf_sample_divider #(
  parameter int TC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            zc_evt,
  input  logic [TC_W-1:0] tc_meas,
  input  logic [TC_W-1:0] tc_q,
  output logic            stb_q
);
  logic [TC_W-1:0] dcnt_q, dcnt_d;
  logic            armed_q, armed_d, stb_d;

  always_comb begin
    dcnt_d  = dcnt_q;
    armed_d = armed_q;
    stb_d   = 1'b0;
    if (!en) begin
      dcnt_d  = '0;
      armed_d = 1'b0;
    end else if (zc_evt) begin
      dcnt_d  = tc_meas - TC_W'(1);
      armed_d = 1'b1;
    end else if (armed_q) begin
      if (dcnt_q == '0) begin
        stb_d  = 1'b1;
        dcnt_d = tc_q - TC_W'(1);
      end else begin
        dcnt_d = dcnt_q - TC_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt_q  <= '0;
      armed_q <= 1'b0;
      stb_q   <= 1'b0;
    end else begin
      dcnt_q  <= dcnt_d;
      armed_q <= armed_d;
      stb_q   <= stb_d;
    end
  end

  p_quiet_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !stb_q);
  p_unarmed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |=> !stb_q);
  p_dcnt_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (dcnt_q < tc_q));
endmodule

// File: rtl/bemf_profile_addr.sv
module bemf_profile_addr #(
  parameter int N_SAMP = 48,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              zc_evt,
  input  logic              stb,
  output logic [ADDR_W-1:0] addr_q
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(N_SAMP - 1);

  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    addr_d = addr_q;
    if (!en || zc_evt)                 addr_d = '0;
    else if (stb && (addr_q != LAST))  addr_d = addr_q + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  p_addr_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_q <= LAST);
  p_addr_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    zc_evt |=> (addr_q == '0));
  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && stb && !zc_evt && (addr_q != LAST)) |=> (addr_q == $past(addr_q) + ADDR_W'(1)));
endmodule

// File: rtl/bemf_sample_seq.sv
module bemf_sample_seq
  import bemf_seq_pkg::*;
#(
  parameter int N_SAMP = DEF_SAMPLES,
  parameter int TC_W   = DEF_TC_W,
  localparam int ADDR_W = $clog2(N_SAMP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              zc_in,
  output logic [TC_W-1:0]   tc,
  output logic              stall,
  output logic              sample_stb,
  output logic [ADDR_W-1:0] prof_addr
);
  logic [1:0]      rst_sync_q;
  logic            rst_sn;
  logic            zc_evt;
  logic [TC_W-1:0] tc_meas;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  bemf_period_timer #(.N_SAMP(N_SAMP), .TC_W(TC_W)) u_timer (
    .clk(clk), .rst_n(rst_sn), .en(en), .zc_in(zc_in),
    .zc_evt(zc_evt), .tc_meas(tc_meas), .tc_q(tc), .stall_q(stall));

  bemf_sample_divider #(.TC_W(TC_W)) u_div (
    .clk(clk), .rst_n(rst_sn), .en(en), .zc_evt(zc_evt),
    .tc_meas(tc_meas), .tc_q(tc), .stb_q(sample_stb));

  bemf_profile_addr #(.N_SAMP(N_SAMP), .ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_sn), .en(en), .zc_evt(zc_evt),
    .stb(sample_stb), .addr_q(prof_addr));
endmodule

// File: tb/bemf_sample_seq_test.sv
module bemf_sample_seq_test;
  localparam int N     = 48;
  localparam int TW    = 8;
  localparam int TMAX  = (1 << TW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic          zc_in = 1'b0;
  logic [TW-1:0] tc;
  logic          stall, sample_stb;
  logic [5:0]    prof_addr;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int exp_cyc[$];
  int exp_addr[$];
  int ref_c = 0, zc_c = 0, cur_t = 0, exp_tc = TMAX;
  bit armed = 1'b0;

  bemf_sample_seq #(.N_SAMP(N), .TC_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .zc_in(zc_in),
    .tc(tc), .stall(stall), .sample_stb(sample_stb), .prof_addr(prof_addr));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // driver side: queue the strobes of the running period up to cycle lim
  task automatic push_strobes(int lim);
    if (armed)
      for (int k = 1; zc_c + k * cur_t + 1 <= lim; k++) begin
        exp_cyc.push_back(zc_c + k * cur_t + 1);
        exp_addr.push_back((k - 1 > N - 1) ? N - 1 : k - 1);
      end
  endtask

  task automatic wait_cycle(int c);
    while (cyc != c) @(negedge clk);
  endtask

  task automatic do_zc(int gap, int hold);
    int c, raw;
    c = ref_c + gap;
    push_strobes(c);
    wait_cycle(c);
    raw = gap / N;
    if (raw > TMAX) check("R8 stall before edge", stall, 1);
    zc_in = 1'b1;
    for (int i = 1; i <= hold; i++) begin
      @(negedge clk);
      if (i == 1) begin
        exp_tc = (raw == 0) ? 1 : ((raw > TMAX) ? TMAX : raw);
        if (raw == 0)        check("R3 zero period as one", tc, exp_tc);
        else if (raw > TMAX) check("R8 saturated capture", tc, exp_tc);
        else                 check("R2 captured period", tc, exp_tc);
        check("R2 stall clear", stall, 0);
        check("R5 address cleared", prof_addr, 0);
      end
    end
    zc_in = 1'b0;  // R7: falling edge and held level carry no event
    zc_c = c; ref_c = c; cur_t = exp_tc; armed = 1'b1;
  endtask

  task automatic disable_at(int gap, int off_len, bit pulse);
    int d;
    d = ref_c + gap;
    push_strobes(d);
    wait_cycle(d);
    en = 1'b0;
    armed = 1'b0;
    repeat (3) @(negedge clk);
    if (pulse) begin
      zc_in = 1'b1;
      repeat (2) @(negedge clk);
      zc_in = 1'b0;
      @(negedge clk);
    end
    check("R9 address held at zero", prof_addr, 0);
    check("R9 stall low", stall, 0);
    check("R9 period kept", tc, exp_tc);
    wait_cycle(d + off_len);
    en = 1'b1;
    ref_c = d + off_len - 1;
  endtask

  // monitor: compare every strobe against the queue
  initial forever begin
    @(negedge clk);
    if (sample_stb) begin
      if (exp_cyc.size() == 0) begin
        check("R10 unexpected strobe", 1, 0);
      end else begin
        int ec, ea;
        ec = exp_cyc.pop_front();
        ea = exp_addr.pop_front();
        check("R4 strobe cycle", cyc, ec);
        check("R6 address at strobe", prof_addr, ea);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 tc reset", tc, TMAX);
    check("R1 stall reset", stall, 0);
    check("R1 strobe reset", sample_stb, 0);
    check("R1 address reset", prof_addr, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    en = 1'b1;
    ref_c = cyc - 1;
    do_zc(500, 1);              // R10: first edge, no strobes before it
    do_zc(480, 1);              // 47 strobes at period 10
    do_zc(700, 3);              // R7 held high, R6 saturation
    do_zc(30, 1);               // R3 gives period 1 next
    do_zc(100, 1);              // strobe every clock
    do_zc(256 * N + 60, 1);     // R8 stall
    disable_at(300, 200, 1'b1); // R9 with ignored edge
    do_zc(960, 1);              // R10 re-armed only here
    do_zc(960, 1);
    disable_at(100, 10, 1'b0);
    repeat (50) @(negedge clk);
    check("R4 all expected strobes seen", exp_cyc.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule